// File: doc/BRIEF.md
# Serial ADC Conversion Sequencer

This block is the host side of a serial link to a four-input, 10-bit successive-approximation converter that runs on an external clock. One request, which names the input channel, the input topology (single-ended or differential) and the output coding (unipolar or bipolar), produces a single conversion. The block drops chip select and shifts out a command byte. It then shifts out two zero bytes while it collects the converter's reply, pulls the 10-bit code out of that reply, raises chip select again and presents the code with a one-cycle valid strobe.

The serial clock rate comes from a programmable half-period in system clocks. An optional idle gap, also programmable, can be placed between bytes. Because the converter's track/hold droops, the block measures the time from the end of the command byte to the end of the reply. It flags the result when that time exceeds a programmed limit. The divider setting must keep the serial clock between 100 kHz and 2 MHz.

Top module: `adc_conv_seq`

## Requirements
- R1: A request (`req_valid` high on a clock edge) is taken only when `busy` is low; `busy` is high from the cycle after acceptance, when `cs_n` falls, until `res_valid` pulses, and a request seen while `busy` is high changes nothing.
- R2: The command byte, sent MSB first, is bit7=1, bits6:4=`req_chan`, bit3=1 for unipolar (`req_bipolar`=0), bit2=`req_single`, bits1:0=2'b11.
- R3: One conversion is exactly 24 rising SCLK edges inside one low period of `cs_n`; MOSI is 0 at every rising edge of the second and third bytes.
- R4: SCLK is low whenever `cs_n` is high; MOSI changes only after a falling SCLK edge; each high phase lasts H system clocks, where H = `div_half`, or 1 when `div_half` is 0.
- R5: Of the 16 reply bits received MSB first on rising edges after the command byte, bits 2 through 11 (counting from 1) form the code MSB first; the first bit, the two sub-bits, the trailing zeros and all bits received during the command byte are ignored.
- R6: With `req_bipolar`=1, `res_data` is the 10-bit code sign-extended as two's complement; otherwise it is zero-extended.
- R7: After the command byte and after the first reply byte, SCLK stays low for `byte_gap` extra system clocks, so the low time before the next rising edge is H+G.
- R8: `res_timeout` is 1 exactly when 32·H + 2·G system clocks (falling edge ending the command byte to the final falling edge) exceed `tmo_limit`.
- R9: `res_valid` is a single-cycle pulse; in its cycle `cs_n` is already high, SCLK is low and `busy` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Conversion request |
| req_chan | input | 3 | Channel-select field of the command byte |
| req_single | input | 1 | 1 = single-ended, 0 = differential |
| req_bipolar | input | 1 | 1 = bipolar (two's complement) result |
| div_half | input | DIV_W | SCLK half period in system clocks (0 acts as 1) |
| byte_gap | input | GAP_W | Idle system clocks inserted between bytes |
| tmo_limit | input | TMO_W | Limit for the conversion-window clock count |
| sclk | output | 1 | Serial clock, idle low |
| cs_n | output | 1 | Converter chip select, active low |
| mosi | output | 1 | Serial data to the converter |
| miso | input | 1 | Serial data from the converter |
| busy | output | 1 | Conversion in progress |
| res_valid | output | 1 | One-cycle result strobe |
| res_data | output | RES_W | Extended conversion result |
| res_timeout | output | 1 | Window exceeded `tmo_limit` |

## Verification
The result strobe and the acceptance of the next request can fall in the same cycle, because the block is idle again in the cycle where `res_valid` is high. The bench provokes this by driving a new request in exactly that cycle. It then checks that chip select falls on the next cycle, that the earlier result is still on `res_data`, and that the second conversion completes with its own command byte and code. A request driven partway through a command byte is also checked: it must leave the captured command byte unchanged and must not start any extra transfer.

// File: rtl/adc_conv_seq.sv
module adc_conv_seq #(
  parameter int DIV_W = 8,
  parameter int GAP_W = 8,
  parameter int TMO_W = 16,
  parameter int RES_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [2:0]       req_chan,
  input  logic             req_single,
  input  logic             req_bipolar,
  input  logic [DIV_W-1:0] div_half,
  input  logic [GAP_W-1:0] byte_gap,
  input  logic [TMO_W-1:0] tmo_limit,
  output logic             sclk,
  output logic             cs_n,
  output logic             mosi,
  input  logic             miso,
  output logic             busy,
  output logic             res_valid,
  output logic [RES_W-1:0] res_data,
  output logic             res_timeout
);
  localparam int PAD = RES_W - 10;

  typedef enum logic [1:0] {S_IDLE, S_SHIFT, S_GAP} st_t;
  st_t st;

  logic [7:0]       ctrl;
  logic             bip;
  logic [DIV_W-1:0] hlim, hc;
  logic [GAP_W-1:0] glim, gc;
  logic [4:0]       bitcnt;
  logic [9:0]       code;
  logic [TMO_W-1:0] tcnt;

  assign cs_n = (st == S_IDLE);
  assign busy = ~cs_n;
  assign mosi = busy && (bitcnt < 5'd8) && ctrl[3'd7 - bitcnt[2:0]];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; ctrl <= '0; bip <= 1'b0; hlim <= '0; hc <= '0;
      glim <= '0; gc <= '0; bitcnt <= '0; code <= '0; tcnt <= '0;
      sclk <= 1'b0; res_valid <= 1'b0; res_data <= '0; res_timeout <= 1'b0;
    end else begin
      res_valid <= 1'b0;
      case (st)
        S_IDLE: if (req_valid) begin
          ctrl   <= {1'b1, req_chan, ~req_bipolar, req_single, 2'b11};
          bip    <= req_bipolar;
          hlim   <= (div_half == '0) ? DIV_W'(1) : div_half;
          glim   <= byte_gap;
          hc     <= '0;
          bitcnt <= '0;
          tcnt   <= '0;
          sclk   <= 1'b0;
          st     <= S_SHIFT;
        end
        S_SHIFT: begin
          if (bitcnt >= 5'd8 && tcnt != '1) tcnt <= tcnt + 1'b1;
          if (hc == hlim - 1'b1) begin
            hc <= '0;
            if (!sclk) begin
              sclk <= 1'b1;
              if (bitcnt >= 5'd9 && bitcnt <= 5'd18) code <= {code[8:0], miso};
            end else begin
              sclk   <= 1'b0;
              bitcnt <= bitcnt + 1'b1;
              if (bitcnt == 5'd23) begin
                st          <= S_IDLE;
                res_valid   <= 1'b1;
                res_data    <= bip ? {{PAD{code[9]}}, code} : {{PAD{1'b0}}, code};
                res_timeout <= (tcnt >= tmo_limit);
              end else if (bitcnt[2:0] == 3'd7 && glim != '0) begin
                gc <= '0;
                st <= S_GAP;
              end
            end
          end else begin
            hc <= hc + 1'b1;
          end
        end
        S_GAP: begin
          if (tcnt != '1) tcnt <= tcnt + 1'b1;
          if (gc == glim - 1'b1) st <= S_SHIFT;
          else gc <= gc + 1'b1;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assert_sclk_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> !sclk);
  assert_mosi_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk && $past(sclk)) |-> $stable(mosi));
  assert_valid_released_R9: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> (cs_n && !sclk));
  assert_valid_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |=> !res_valid);
  assert_busy_end_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> res_valid);
endmodule

// File: tb/tb_adc_conv_seq.sv
`timescale 1ns/1ps
module tb_adc_conv_seq;
  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_single = 1'b0, req_bipolar = 1'b0;
  logic [2:0] req_chan = '0;
  logic [7:0] div_half = 8'd1, byte_gap = '0;
  logic [15:0] tmo_limit = '1;
  logic sclk, cs_n, mosi, busy, res_valid, res_timeout;
  logic miso = 1'b0;
  logic [15:0] res_data;

  adc_conv_seq dut (.clk, .rst_n, .req_valid, .req_chan, .req_single, .req_bipolar,
    .div_half, .byte_gap, .tmo_limit, .sclk, .cs_n, .mosi, .miso, .busy,
    .res_valid, .res_data, .res_timeout);

  always #10 clk = ~clk;

  int total = 0, fails = 0;
  int rises, falls, mosi_err, width_err, gap_meas, exp_h;
  logic [7:0] cap_ctrl;
  logic [15:0] frame;
  time t_rise, t_f8;

  always @(negedge cs_n) begin
    rises = 0; falls = 0; mosi_err = 0; width_err = 0; gap_meas = -1;
    miso = 1'($urandom);
  end
  always @(posedge sclk) begin
    if (rises < 8) cap_ctrl = {cap_ctrl[6:0], mosi};
    else if (mosi !== 1'b0) mosi_err++;
    if (rises == 8) gap_meas = int'(($time - t_f8) / 20);
    rises++;
    t_rise = $time;
  end
  always @(negedge sclk) begin
    if (int'(($time - t_rise) / 20) != exp_h) width_err++;
    falls++;
    if (falls == 8) t_f8 = $time;
    if (falls >= 8 && falls < 24) miso = frame[15 - (falls - 8)];
    else miso = 1'($urandom);
  end

  task automatic chk(input bit ok, input string tag, input longint act, input longint expv);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  function automatic logic [15:0] exp_res(input bit b, input logic [9:0] c);
    return b ? {{6{c[9]}}, c} : {6'b0, c};
  endfunction

  logic [7:0] e_ctrl;
  logic [9:0] e_code;
  bit e_bip, e_tmo;
  int e_gap;

  task automatic launch(input logic [2:0] ch, input bit sg, input bit bp, input int dv,
                        input int gp, input int lim, input logic [9:0] cd);
    exp_h  = (dv == 0) ? 1 : dv;
    e_gap  = gp;
    e_ctrl = {1'b1, ch, ~bp, sg, 2'b11};
    e_code = cd;
    e_bip  = bp;
    e_tmo  = (32 * exp_h + 2 * gp) > lim;
    frame  = {1'b0, cd, 2'($urandom), 3'b000};
    req_chan = ch; req_single = sg; req_bipolar = bp;
    div_half = 8'(dv); byte_gap = 8'(gp); tmo_limit = 16'(lim);
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic finish_check();
    int n = 0;
    while (!res_valid && n < 20000) begin @(negedge clk); n++; end
    chk(res_valid, "R9 result strobe", res_valid, 1);
    chk(cs_n && !busy && !sclk, "R9 released at strobe", {cs_n, busy, sclk}, 3'b100);
    chk(cap_ctrl == e_ctrl, "R2 command byte", cap_ctrl, e_ctrl);
    chk(rises == 24, "R3 sclk count", rises, 24);
    chk(mosi_err == 0, "R3 zero bytes", mosi_err, 0);
    chk(width_err == 0, "R4 high phase", width_err, 0);
    chk(gap_meas == exp_h + e_gap, "R7 byte gap", gap_meas, exp_h + e_gap);
    chk(res_data == exp_res(e_bip, e_code), "R5 R6 result", res_data, exp_res(e_bip, e_code));
    chk(res_timeout == e_tmo, "R8 timeout", res_timeout, e_tmo);
  endtask

  task automatic do_conv(input logic [2:0] ch, input bit sg, input bit bp, input int dv,
                         input int gp, input int lim, input logic [9:0] cd, input bit poke);
    @(negedge clk);
    launch(ch, sg, bp, dv, gp, lim, cd);
    chk(busy && !cs_n, "R1 busy after accept", busy, 1);
    if (poke) begin
      repeat (3) @(negedge clk);
      req_chan = ~ch; req_single = ~sg; req_bipolar = ~bp; req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
    end
    finish_check();
  endtask

  initial begin
    #4_000_000;
    fails++; total++;
    $display("FAIL R1 watchdog actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", total, fails);
    $finish;
  end

  initial begin
    logic [15:0] held;
    void'($urandom(32'h5eed));
    repeat (3) @(negedge clk);
    chk(cs_n && !sclk && !busy && !res_valid, "R9 reset state", {cs_n, sclk, busy, res_valid}, 4'b1000);
    rst_n = 1'b1;
    @(negedge clk);
    // directed corners
    do_conv(3'd0, 1'b1, 1'b0, 0, 0, 100000, 10'h3FF, 1'b0);
    do_conv(3'd5, 1'b0, 1'b1, 2, 3, 100000, 10'h200, 1'b1);
    do_conv(3'd7, 1'b1, 1'b1, 3, 4, 32*3 + 8, 10'h1FF, 1'b0);      // R8 at the limit
    do_conv(3'd2, 1'b0, 1'b0, 3, 4, 32*3 + 7, 10'h000, 1'b0);      // R8 one past
    // R1: request in the strobe cycle starts the next conversion
    held = res_data;
    launch(3'd4, 1'b1, 1'b0, 1, 2, 100000, 10'h2A5);
    chk(!cs_n && busy, "R1 back-to-back accept", cs_n, 0);
    chk(res_data == held, "R1 previous result held", res_data, held);
    finish_check();
    repeat (3) @(negedge clk);
    chk(cs_n, "R1 no extra transfer", cs_n, 1);
    // random
    for (int i = 0; i < 30; i++) begin
      int dv = $urandom_range(0, 5);
      int gp = $urandom_range(0, 6);
      int he = (dv == 0) ? 1 : dv;
      int lim = 32 * he + 2 * gp + $urandom_range(0, 4) - 2;
      do_conv(3'($urandom), 1'($urandom), 1'($urandom), dv, gp, lim, 10'($urandom), 1'($urandom));
      repeat ($urandom_range(0, 3)) @(negedge clk);
    end
    $display("[TB] %0d tests run, %0d failed", total, fails);
    $finish;
  end
endmodule